// File: doc/BRIEF.md
# Exception Entry and Return Unit

This block is the piece of a processor core that changes architectural state when an exception is taken or left. When a synchronous cause or an enabled external interrupt is accepted, it saves the interrupted program counter and the whole machine-state word into two save registers. It then drops the core into supervisor mode, closes the external interrupt gate and marks the state as not recoverable. It also emits a one-cycle redirect carrying the handler address.

The handler address is a base plus a per-cause offset. The base is either zero or a high address, chosen by a vector-select bit in the state word. A return strobe copies the saved state back into the state word and redirects to the saved program counter in a single cycle. A special-register port lets software write and read the state word and both save registers. Software re-opens the interrupt gate and the recoverable flag this way, which allows nesting.

Top module: `exc_unit`

## Requirements
- R1: On an accepted exception, the saved-PC register takes `cur_pc` and the saved-state register takes the full state word as it was before that edge.
- R2: On an accepted exception, state bits 0 (user mode, 1 = user), 1 (external interrupt enable) and 2 (recoverable) are cleared. All other state bits keep their values.
- R3: One cycle after acceptance, `redirect_vld` is high for exactly one cycle. `redirect_pc` equals base plus offset. The base is 0 when state bit 3 is clear and 0xFFF00000 when it is set. The offset is 0x200 + 0x100*i for synchronous cause i and 0x500 for the external interrupt.
- R4: `ext_irq` is accepted only while state bit 1 is set. Otherwise it is ignored: there is no redirect and no save register or state bit changes.
- R5: When several causes are raised in one cycle, the lowest-indexed synchronous cause wins, and any synchronous cause beats the external interrupt. Only the winner is saved and vectored.
- R6: On `rfe`, the state word takes the saved-state value and `redirect_pc` takes the saved PC, with `redirect_vld` high, all in one cycle. Both save registers are unchanged.
- R7: When `wr_en` is high, `wr_data` is written to the register picked by `wr_sel` (0 state word, 1 saved PC, 2 saved state, 3 none), visible after that edge. Setting bits 1 and 2 this way re-enables nested external interrupts.
- R8: `rd_data` is registered. It shows the register picked by `rd_sel` (same encoding as `wr_sel`) as it was before the edge, and it is 0 for select 3.
- R9: In one cycle, exception entry beats `rfe`, and `rfe` beats a software write; the losing action is dropped. The external interrupt gate is the state bit 1 value from before the edge.
- R10: After reset, the state word, both save registers, `redirect_pc` and `rd_data` are 0, and `redirect_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | NCAUSE | Synchronous exception causes, index 0 highest priority |
| ext_irq | input | 1 | External interrupt request |
| cur_pc | input | XLEN | PC of the interrupted instruction |
| rfe | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Special-register write enable |
| wr_sel | input | 2 | Write target select |
| wr_data | input | XLEN | Write data |
| rd_sel | input | 2 | Read source select |
| rd_data | output | XLEN | Registered read data |
| redirect_vld | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | XLEN | New program counter |
| state_o | output | SW | Current machine-state word |

## Verification
Exception entry can land in the same cycle as a return strobe or a software write. An external interrupt can also arrive in the very cycle that software sets the enable bit. The bench drives each such pair in one cycle. It then reads the state word and both save registers through the read port and checks that entry won and the other action vanished. In the enable case, it checks that the interrupt stayed ignored while the write still took effect.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int BIT_USER  = 0;
  localparam int BIT_EXTEN = 1;
  localparam int BIT_RECOV = 2;
  localparam int BIT_HIVEC = 3;

  typedef enum logic [1:0] {
    SR_STATE  = 2'd0,
    SR_SPC    = 2'd1,
    SR_SSTATE = 2'd2,
    SR_NONE   = 2'd3
  } sr_sel_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NCAUSE = 3,
  localparam int IDXW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1
) (
  input  logic [NCAUSE-1:0] exc_req,
  input  logic              ext_irq,
  input  logic              ext_en,
  output logic              take,
  output logic              is_ext,
  output logic [IDXW-1:0]   cause_idx
);
  logic any_sync;

  always_comb begin
    any_sync  = 1'b0;
    cause_idx = '0;
    // scan downward so the lowest index is written last and wins
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (exc_req[i]) begin
        any_sync  = 1'b1;
        cause_idx = IDXW'(i);
      end
    end
    is_ext = !any_sync && ext_irq && ext_en;
    take   = any_sync || is_ext;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int XLEN = 32,
  parameter int NCAUSE = 3,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFF0_0000,
  parameter int SYNC_BASE = 'h200,
  parameter int SYNC_STEP = 'h100,
  parameter int EXT_OFF = 'h500,
  localparam int IDXW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1
) (
  input  logic            hi_vec,
  input  logic            is_ext,
  input  logic [IDXW-1:0] cause_idx,
  output logic [XLEN-1:0] vec_pc
);
  logic [XLEN-1:0] offs [NCAUSE];
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] off;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_off
    assign offs[g] = XLEN'(SYNC_BASE + SYNC_STEP * g);
  end

  always_comb begin
    base = hi_vec ? HI_BASE : '0;
    off  = is_ext ? XLEN'(EXT_OFF) : offs[cause_idx];
    vec_pc = base + off;
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [XLEN-1:0] vec_pc,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            rfe,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      rd_sel,
  output logic [SW-1:0]   state,
  output logic [XLEN-1:0] spc,
  output logic [SW-1:0]   sstate,
  output logic            redirect_vld,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] rd_data
);
  localparam logic [SW-1:0] CLR_MASK =
    SW'((1 << BIT_USER) | (1 << BIT_EXTEN) | (1 << BIT_RECOV));

  logic [XLEN-1:0] rd_mux;

  always_comb begin
    case (rd_sel)
      SR_STATE:  rd_mux = XLEN'(state);
      SR_SPC:    rd_mux = spc;
      SR_SSTATE: rd_mux = XLEN'(sstate);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= '0;
      spc          <= '0;
      sstate       <= '0;
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
      rd_data      <= '0;
    end else begin
      rd_data      <= rd_mux;
      redirect_vld <= take || rfe;
      if (take) begin
        spc         <= cur_pc;
        sstate      <= state;
        state       <= state & ~CLR_MASK;
        redirect_pc <= vec_pc;
      end else if (rfe) begin
        state       <= sstate;
        redirect_pc <= spc;
      end else if (wr_en) begin
        case (wr_sel)
          SR_STATE:  state  <= wr_data[SW-1:0];
          SR_SPC:    spc    <= wr_data;
          SR_SSTATE: sstate <= wr_data[SW-1:0];
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SW = 32,
  parameter int NCAUSE = 3,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFF0_0000,
  parameter int SYNC_BASE = 'h200,
  parameter int SYNC_STEP = 'h100,
  parameter int EXT_OFF = 'h500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:0] exc_req,
  input  logic              ext_irq,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              rfe,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [1:0]        rd_sel,
  output logic [XLEN-1:0]   rd_data,
  output logic              redirect_vld,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [SW-1:0]     state_o
);
  localparam int IDXW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1;

  logic            take;
  logic            is_ext;
  logic [IDXW-1:0] cause_idx;
  logic [XLEN-1:0] vec_pc;
  logic [SW-1:0]   state;
  logic [XLEN-1:0] spc;
  logic [SW-1:0]   sstate;

  exc_arbiter #(.NCAUSE(NCAUSE)) u_arb (
    .exc_req  (exc_req),
    .ext_irq  (ext_irq),
    .ext_en   (state[BIT_EXTEN]),
    .take     (take),
    .is_ext   (is_ext),
    .cause_idx(cause_idx)
  );

  exc_vector #(
    .XLEN(XLEN), .NCAUSE(NCAUSE), .HI_BASE(HI_BASE),
    .SYNC_BASE(SYNC_BASE), .SYNC_STEP(SYNC_STEP), .EXT_OFF(EXT_OFF)
  ) u_vec (
    .hi_vec   (state[BIT_HIVEC]),
    .is_ext   (is_ext),
    .cause_idx(cause_idx),
    .vec_pc   (vec_pc)
  );

  exc_state_regs #(.XLEN(XLEN), .SW(SW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .vec_pc      (vec_pc),
    .cur_pc      (cur_pc),
    .rfe         (rfe),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_sel      (rd_sel),
    .state       (state),
    .spc         (spc),
    .sstate      (sstate),
    .redirect_vld(redirect_vld),
    .redirect_pc (redirect_pc),
    .rd_data     (rd_data)
  );

  assign state_o = state;
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SW = 32,
  parameter int NCAUSE = 3,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFF0_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [NCAUSE-1:0] exc_req,
  input logic              ext_irq,
  input logic [XLEN-1:0]   cur_pc,
  input logic              rfe,
  input logic              redirect_vld,
  input logic [XLEN-1:0]   redirect_pc,
  input logic [SW-1:0]     state_o,
  input logic [XLEN-1:0]   spc,
  input logic [SW-1:0]     sstate
);
  logic entry;
  assign entry = (|exc_req) || (ext_irq && state_o[BIT_EXTEN]);

  // R1
  a_r1_save_pc: assert property (@(posedge clk) disable iff (rst)
    entry |=> (spc == $past(cur_pc)) && (sstate == $past(state_o)));
  // R2
  a_r2_bits_cleared: assert property (@(posedge clk) disable iff (rst)
    entry |=> !state_o[BIT_USER] && !state_o[BIT_EXTEN] && !state_o[BIT_RECOV]);
  // R3
  a_r3_base_select: assert property (@(posedge clk) disable iff (rst)
    entry |=> redirect_vld &&
      ((redirect_pc & HI_BASE) == ($past(state_o[BIT_HIVEC]) ? HI_BASE : '0)));
  // R4
  a_r4_masked_irq: assert property (@(posedge clk) disable iff (rst)
    (!(|exc_req) && ext_irq && !state_o[BIT_EXTEN] && !rfe) |=>
      !redirect_vld && $stable(spc) && $stable(sstate));
  // R6
  a_r6_return: assert property (@(posedge clk) disable iff (rst)
    (rfe && !entry) |=> redirect_vld && (state_o == $past(sstate)) &&
      (redirect_pc == $past(spc)) && $stable(spc) && $stable(sstate));
endmodule

bind exc_unit exc_unit_chk #(
  .XLEN(XLEN), .SW(SW), .NCAUSE(NCAUSE), .HI_BASE(HI_BASE)
) u_chk (
  .clk(clk), .rst(rst), .exc_req(exc_req), .ext_irq(ext_irq),
  .cur_pc(cur_pc), .rfe(rfe), .redirect_vld(redirect_vld),
  .redirect_pc(redirect_pc), .state_o(state_o), .spc(spc), .sstate(sstate)
);

// File: tb/tb_exc_unit.sv
`timescale 1ns/1ps
module tb_exc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  exc_req;
  logic        ext_irq;
  logic [31:0] cur_pc;
  logic        rfe;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        redirect_vld;
  logic [31:0] redirect_pc;
  logic [31:0] state_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_unit dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .ext_irq(ext_irq),
    .cur_pc(cur_pc), .rfe(rfe), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .state_o(state_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    exc_req = '0; ext_irq = 0; cur_pc = '0; rfe = 0;
    wr_en = 0; wr_sel = 2'd3; wr_data = '0;
  endtask

  // one cycle of stimulus; outputs sampled 1 ns after the edge
  task automatic cyc(input logic [2:0] rq, input logic ei, input logic [31:0] pc,
                     input logic rt, input logic we, input logic [1:0] ws,
                     input logic [31:0] wd);
    exc_req = rq; ext_irq = ei; cur_pc = pc; rfe = rt;
    wr_en = we; wr_sel = ws; wr_data = wd;
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    cyc(3'b000, 0, 32'h0, 0, 1, sel, d);
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 vld", {31'b0, redirect_vld}, 32'h0);
    chk("R10 state", state_o, 32'h0);
    chk("R10 pc", redirect_pc, 32'h0);
    chk("R10 rdata", rd_data, 32'h0);
    rd(2'd1, v); chk("R10 spc", v, 32'h0);
    rd(2'd2, v); chk("R10 sstate", v, 32'h0);
  endtask

  task automatic t_sync_entry();
    logic [31:0] v;
    wr(2'd0, 32'h0000_00F7);
    cyc(3'b001, 0, 32'h0000_1234, 0, 0, 2'd3, 0);
    chk("R3 vld", {31'b0, redirect_vld}, 32'h1);
    chk("R3 pc cause0 low", redirect_pc, 32'h0000_0200);
    chk("R2 clear", state_o, 32'h0000_00F0);
    rd(2'd1, v); chk("R1 spc", v, 32'h0000_1234);
    chk("R3 single pulse", {31'b0, redirect_vld}, 32'h0);
    rd(2'd2, v); chk("R1 sstate", v, 32'h0000_00F7);
  endtask

  task automatic t_high_base();
    wr(2'd0, 32'h0000_000F);
    cyc(3'b100, 0, 32'h10, 0, 0, 2'd3, 0);
    chk("R3 pc cause2 high", redirect_pc, 32'hFFF0_0400);
    chk("R2 keep vec bit", state_o, 32'h0000_0008);
  endtask

  task automatic t_ext_masked();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0005);
    wr(2'd1, 32'h0000_0AAA);
    cyc(3'b000, 1, 32'h0000_0BBB, 0, 0, 2'd3, 0);
    chk("R4 no redirect", {31'b0, redirect_vld}, 32'h0);
    chk("R4 state kept", state_o, 32'h0000_0005);
    rd(2'd1, v); chk("R4 spc kept", v, 32'h0000_0AAA);
  endtask

  task automatic t_ext_taken();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0002);
    cyc(3'b000, 1, 32'h0000_0C00, 0, 0, 2'd3, 0);
    chk("R3 ext vec", redirect_pc, 32'h0000_0500);
    chk("R2 ext clear", state_o, 32'h0);
    rd(2'd1, v); chk("R1 ext spc", v, 32'h0000_0C00);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0002);
    cyc(3'b110, 1, 32'h0000_0D00, 0, 0, 2'd3, 0);
    chk("R5 cause1 wins", redirect_pc, 32'h0000_0300);
    rd(2'd1, v); chk("R5 winner saved", v, 32'h0000_0D00);
    cyc(3'b101, 0, 32'h0000_0E00, 0, 0, 2'd3, 0);
    chk("R5 cause0 wins", redirect_pc, 32'h0000_0200);
  endtask

  task automatic t_rfe();
    logic [31:0] v;
    wr(2'd1, 32'h000A_BCD0);
    wr(2'd2, 32'h0000_0007);
    wr(2'd0, 32'h0000_0000);
    cyc(3'b000, 0, 0, 1, 0, 2'd3, 0);
    chk("R6 vld", {31'b0, redirect_vld}, 32'h1);
    chk("R6 pc", redirect_pc, 32'h000A_BCD0);
    chk("R6 state", state_o, 32'h0000_0007);
    rd(2'd1, v); chk("R6 spc kept", v, 32'h000A_BCD0);
    rd(2'd2, v); chk("R6 sstate kept", v, 32'h0000_0007);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0006);
    wr(2'd2, 32'h0000_0055);
    wr(2'd1, 32'h0000_0099);
    cyc(3'b001, 0, 32'h0000_0040, 1, 0, 2'd3, 0);
    chk("R9 entry beats rfe pc", redirect_pc, 32'h0000_0200);
    chk("R9 entry beats rfe state", state_o, 32'h0);
    rd(2'd2, v); chk("R9 sstate", v, 32'h0000_0006);
    rd(2'd1, v); chk("R9 spc", v, 32'h0000_0040);
    wr(2'd0, 32'h0000_0002);
    cyc(3'b001, 0, 32'h0000_0044, 0, 1, 2'd0, 32'h0000_00FF);
    chk("R9 entry beats write", state_o, 32'h0);
    cyc(3'b000, 1, 32'h0000_0048, 0, 1, 2'd0, 32'h0000_0002);
    chk("R9 old gate", {31'b0, redirect_vld}, 32'h0);
    chk("R9 write applied", state_o, 32'h0000_0002);
    wr(2'd2, 32'h0000_0030);
    cyc(3'b000, 0, 0, 1, 1, 2'd0, 32'h0000_00FF);
    chk("R9 rfe beats write", state_o, 32'h0000_0030);
  endtask

  task automatic t_nested();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0000);
    cyc(3'b000, 1, 32'h0000_0500, 0, 0, 2'd3, 0);
    chk("R7 gate closed", {31'b0, redirect_vld}, 32'h0);
    wr(2'd0, 32'h0000_0006);
    chk("R7 write state", state_o, 32'h0000_0006);
    cyc(3'b000, 1, 32'h0000_0600, 0, 0, 2'd3, 0);
    chk("R7 nested taken", redirect_pc, 32'h0000_0500);
    rd(2'd2, v); chk("R7 nested sstate", v, 32'h0000_0006);
  endtask

  task automatic t_read();
    logic [31:0] v;
    wr(2'd1, 32'h1357_9BDF);
    rd(2'd3, v); chk("R8 sel3 zero", v, 32'h0);
    rd(2'd1, v); chk("R8 read spc", v, 32'h1357_9BDF);
    rd(2'd0, v); chk("R8 read state", v, state_o);
  endtask

  initial begin
    clear_in();
    rd_sel = 2'd0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_sync_entry();
    t_high_base();
    t_ext_masked();
    t_ext_taken();
    t_priority();
    t_rfe();
    t_same_cycle();
    t_nested();
    t_read();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule